// File: doc/BRIEF.md
# Wait-for-Interrupt Wake Controller

This block sits inside a small CPU core and governs the low-power wait state entered by a wait-for-interrupt opcode. When the decoder pulses `halt_op_i`, the block drops the core's ready and clock-enable lines. It keeps them low until a hardware wake source arrives. It then reports, in one pulse, how the wait ended. The wait either resumes at the next instruction with no service sequence, or it starts a vectored sequence with a one-hot vector select and a flag that tells the stack logic which return address to save.

The four wake sources are reset request, abort, NMI and IRQ. All are active-low and pass through a parameterised synchroniser. NMI is edge-latched and stays pending until the core acknowledges it. A masked IRQ still wakes the core and resumes it directly, with no stack pushes. Abort services its handler but returns to the wait opcode, so the core waits again afterwards. One fixed priority resolves all sources: reset request first, then abort, then NMI, then IRQ.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After `rst_ni` is released, `rdy_o` and `clk_en_o` are 1, and `resume_o`, `take_vec_o`, `vec_sel_o` and `ret_self_o` are 0.
- R2: A `halt_op_i` pulse with no wake source pending drops `rdy_o` and `clk_en_o` at the next clock edge. Both stay low while no source is present.
- R3: With `iflag_i`=1, an IRQ during the wait raises `rdy_o` and pulses `resume_o` on the edge after the synchronised sample. That is the (SYNC_STAGES+1)-th rising edge with `irq_ni` low. `take_vec_o` stays 0.
- R4: With `iflag_i`=0, an IRQ during the wait pulses `take_vec_o` with `vec_sel_o`=4'b1000 and `ret_self_o`=0.
- R5: A falling edge on `nmi_ni` during the wait pulses `take_vec_o` with `vec_sel_o`=4'b0100 and `ret_self_o`=0, whatever the value of `iflag_i`.
- R6: Abort during the wait pulses `take_vec_o` with `vec_sel_o`=4'b0010 and `ret_self_o`=1, so the return address is the wait opcode.
- R7: Reset request during the wait pulses `take_vec_o` with `vec_sel_o`=4'b0001. Reset request also clears a latched NMI.
- R8: Priority is reset request, then abort, then NMI, then IRQ. When NMI and an unmasked IRQ arrive together, NMI is taken and the IRQ stays pending, so the next wait ends at once with the IRQ vector.
- R9: If a wake source is already present on the edge where `halt_op_i` is sampled, the outcome pulse appears after that same edge and `rdy_o` never drops.
- R10: `resume_o`, `take_vec_o` and `ret_self_o` are single-cycle pulses. `resume_o` and `take_vec_o` are never high together. `vec_sel_o` is one-hot while `take_vec_o` is high and zero otherwise.
- R11: A latched NMI persists, even after `nmi_ni` returns high, until `nmi_ack_i`. An `nmi_ni` held low after acknowledge does not latch again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| halt_op_i | input | 1 | One-cycle pulse: wait opcode executes |
| iflag_i | input | 1 | Interrupt-disable flag (masks IRQ service only) |
| reset_req_ni | input | 1 | Active-low reset-request wake source |
| abort_ni | input | 1 | Active-low abort level |
| nmi_ni | input | 1 | Active-low NMI, falling-edge sensitive |
| irq_ni | input | 1 | Active-low IRQ level |
| nmi_ack_i | input | 1 | NMI sequence acknowledged, clears the NMI latch |
| rdy_o | output | 1 | Ready, low while waiting |
| clk_en_o | output | 1 | Core clock enable, low while waiting |
| resume_o | output | 1 | Pulse: continue at next instruction, no service |
| take_vec_o | output | 1 | Pulse: start vectored sequence |
| vec_sel_o | output | 4 | One-hot vector: bit0 reset, bit1 abort, bit2 NMI, bit3 IRQ |
| ret_self_o | output | 1 | Pulse with take: save the wait opcode address as return |

## Verification
Assertions check on every cycle the pulse shape and the one-hot vector encoding. They also check that halting follows an unserviced wait opcode, that a masked IRQ wakes one edge after its sample, the priority of NMI over IRQ and of reset over all, the abort return flag, and the NMI latch holding until acknowledge or reset. Only the bench scenarios can show the end-to-end latency from a pin change through the synchroniser. They also show that a deferred IRQ is still honoured on a later wait, and that a held NMI level or a reset-cleared latch leaves the core waiting.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;
  localparam int N_SRC = 4;
  localparam int SRC_RST = 3;
  localparam int SRC_ABT = 2;
  localparam int SRC_NMI = 1;
  localparam int SRC_IRQ = 0;

  localparam logic [3:0] VEC_RST = 4'b0001;
  localparam logic [3:0] VEC_ABT = 4'b0010;
  localparam logic [3:0] VEC_NMI = 4'b0100;
  localparam logic [3:0] VEC_IRQ = 4'b1000;

  typedef enum logic {S_RUN, S_WAIT} hstate_t;

  typedef struct packed {
    logic       resume;
    logic       take;
    logic [3:0] vec;
    logic       ret_self;
  } wake_dec_t;
endpackage

// File: rtl/hw_sync.sv
module hw_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] in_ni,
  output logic [WIDTH-1:0] act_o
);
  logic [WIDTH-1:0] q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) q[k] <= '1;
    end else begin
      q[0] <= in_ni;
      for (int k = 1; k < STAGES; k++) q[k] <= q[k-1];
    end
  end

  assign act_o = ~q[STAGES-1];
endmodule

// File: rtl/hw_nmi_latch.sv
module hw_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_s_i,
  input  logic ack_i,
  input  logic clr_i,
  output logic pend_o,
  output logic edge_o
);
  logic prev_q, pend_q;

  assign edge_o = nmi_s_i & ~prev_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_s_i;
      if (clr_i)       pend_q <= 1'b0;
      else if (edge_o) pend_q <= 1'b1;  // new edge beats a stale ack
      else if (ack_i)  pend_q <= 1'b0;
    end
  end

  p_nmi_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !ack_i && !clr_i |=> pend_q);
  p_nmi_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o && !clr_i |=> pend_q);
  p_nmi_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_q);
endmodule

// File: rtl/hw_arb.sv
module hw_arb
  import halt_wake_pkg::*;
(
  input  logic      waiting_i,
  input  logic      rst_i,
  input  logic      abt_i,
  input  logic      nmi_i,
  input  logic      irq_i,
  input  logic      iflag_i,
  output wake_dec_t dec_o
);
  always_comb begin
    dec_o = '0;
    if (waiting_i) begin
      if (rst_i) begin
        dec_o.take = 1'b1;
        dec_o.vec  = VEC_RST;
      end else if (abt_i) begin
        dec_o.take     = 1'b1;
        dec_o.vec      = VEC_ABT;
        dec_o.ret_self = 1'b1;
      end else if (nmi_i) begin
        dec_o.take = 1'b1;
        dec_o.vec  = VEC_NMI;
      end else if (irq_i) begin
        if (iflag_i) begin
          dec_o.resume = 1'b1;
        end else begin
          dec_o.take = 1'b1;
          dec_o.vec  = VEC_IRQ;
        end
      end
    end
  end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_op_i,
  input  logic       iflag_i,
  input  logic       reset_req_ni,
  input  logic       abort_ni,
  input  logic       nmi_ni,
  input  logic       irq_ni,
  input  logic       nmi_ack_i,
  output logic       rdy_o,
  output logic       clk_en_o,
  output logic       resume_o,
  output logic       take_vec_o,
  output logic [3:0] vec_sel_o,
  output logic       ret_self_o
);
  logic [N_SRC-1:0] src_s;
  logic             nmi_pend, nmi_edge, nmi_any, eff_wait;
  hstate_t          state_q;
  wake_dec_t        dec, out_q;

  hw_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_ni ({reset_req_ni, abort_ni, nmi_ni, irq_ni}),
    .act_o (src_s)
  );

  hw_nmi_latch u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_s_i(src_s[SRC_NMI]),
    .ack_i  (nmi_ack_i),
    .clr_i  (src_s[SRC_RST]),
    .pend_o (nmi_pend),
    .edge_o (nmi_edge)
  );

  // an edge seen this cycle counts as pending, aligning NMI with level sources
  assign nmi_any  = (nmi_pend | nmi_edge) & ~src_s[SRC_RST];
  assign eff_wait = (state_q == S_WAIT) | halt_op_i;

  hw_arb u_arb (
    .waiting_i(eff_wait),
    .rst_i    (src_s[SRC_RST]),
    .abt_i    (src_s[SRC_ABT]),
    .nmi_i    (nmi_any),
    .irq_i    (src_s[SRC_IRQ]),
    .iflag_i  (iflag_i),
    .dec_o    (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_RUN;
      out_q   <= '0;
    end else begin
      out_q <= dec;
      if (dec.resume || dec.take || src_s[SRC_RST]) state_q <= S_RUN;
      else if (halt_op_i)                           state_q <= S_WAIT;
    end
  end

  assign rdy_o      = (state_q == S_RUN);
  assign clk_en_o   = (state_q == S_RUN);
  assign resume_o   = out_q.resume;
  assign take_vec_o = out_q.take;
  assign vec_sel_o  = out_q.vec;
  assign ret_self_o = out_q.ret_self;

  p_vec_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vec_sel_o) && (take_vec_o == (vec_sel_o != 4'b0)));
  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resume_o && take_vec_o));
  p_halt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && halt_op_i && !src_s[SRC_RST] && !src_s[SRC_ABT] && !nmi_any && !src_s[SRC_IRQ])
    |=> !rdy_o && !clk_en_o);
  p_masked_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_wait && src_s[SRC_IRQ] && iflag_i && !src_s[SRC_RST] && !src_s[SRC_ABT] && !nmi_any)
    |=> resume_o && rdy_o && !take_vec_o);
  p_abort_ret_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_vec_o && vec_sel_o[1]) |-> ret_self_o);
  p_nmi_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_wait && nmi_any && src_s[SRC_IRQ] && !src_s[SRC_RST] && !src_s[SRC_ABT])
    |=> vec_sel_o == VEC_NMI);
  p_reset_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_wait && src_s[SRC_RST]) |=> vec_sel_o == VEC_RST && rdy_o);
endmodule

// File: tb/tb_halt_wake_ctrl.sv
module tb_halt_wake_ctrl;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic halt_op = 1'b0, iflag = 1'b0, nmi_ack = 1'b0;
  logic reset_req_n = 1'b1, abort_n = 1'b1, nmi_n = 1'b1, irq_n = 1'b1;
  logic rdy, clk_en, resume, take_vec, ret_self;
  logic [3:0] vec_sel;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  halt_wake_ctrl #(.SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .halt_op_i(halt_op), .iflag_i(iflag),
    .reset_req_ni(reset_req_n), .abort_ni(abort_n), .nmi_ni(nmi_n), .irq_ni(irq_n),
    .nmi_ack_i(nmi_ack), .rdy_o(rdy), .clk_en_o(clk_en), .resume_o(resume),
    .take_vec_o(take_vec), .vec_sel_o(vec_sel), .ret_self_o(ret_self)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  function automatic logic [6:0] obs();
    return {resume, take_vec, vec_sel, ret_self};
  endfunction

  function automatic logic [6:0] expect_fn(logic r, logic a, logic n, logic i, logic f);
    if (r) return {2'b01, 4'b0001, 1'b0};
    if (a) return {2'b01, 4'b0010, 1'b1};
    if (n) return {2'b01, 4'b0100, 1'b0};
    if (i) return f ? {2'b10, 4'b0000, 1'b0} : {2'b01, 4'b1000, 1'b0};
    return 7'b0;
  endfunction

  function automatic string tag_fn(logic r, logic a, logic n, logic i, logic f);
    string t;
    t = r ? "R7" : a ? "R6" : n ? "R5" : (i && f) ? "R3" : "R4";
    if ((32'(r) + 32'(a) + 32'(n) + 32'(i)) > 1) t = {t, "/R8"};
    return t;
  endfunction

  task automatic enter_wait();
    halt_op = 1'b1; step(1); halt_op = 1'b0;
    chk("R2 rdy low", 32'(rdy), 0);
    chk("R2 clk_en low", 32'(clk_en), 0);
  endtask

  task automatic exit_masked();
    iflag = 1'b1; irq_n = 1'b0;
    step(SYNC + 1);
    chk("R3 masked exit", 32'({resume, take_vec, rdy}), 32'b101);
    irq_n = 1'b1; step(SYNC + 2);
  endtask

  task automatic run_case(logic r, logic a, logic n, logic i, logic f);
    string t;
    t = tag_fn(r, a, n, i, f);
    iflag = f;
    enter_wait();
    step(2);
    chk("R2 holds", 32'({rdy, obs()}), 0);
    reset_req_n = ~r; abort_n = ~a; nmi_n = ~n; irq_n = ~i;
    step(SYNC);
    chk({t, " before sample edge"}, 32'({rdy, obs()}), 0);
    step(1);
    chk(t, 32'(obs()), 32'(expect_fn(r, a, n, i, f)));
    chk({t, " rdy up"}, 32'(rdy), 1);
    step(1);
    chk("R10 single pulse", 32'(obs()), 0);
    reset_req_n = 1'b1; abort_n = 1'b1; nmi_n = 1'b1; irq_n = 1'b1;
    if (n && !r) begin nmi_ack = 1'b1; step(1); nmi_ack = 1'b0; end
    step(SYNC + 2);
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 rdy/clk_en", 32'({rdy, clk_en}), 32'b11);
    chk("R1 pulses", 32'(obs()), 0);

    // directed single sources
    run_case(0, 0, 0, 1, 1);   // R3
    run_case(0, 0, 0, 1, 0);   // R4
    run_case(0, 0, 1, 0, 1);   // R5 with flag set
    run_case(0, 1, 0, 0, 0);   // R6
    run_case(1, 0, 0, 0, 0);   // R7
    run_case(1, 1, 1, 1, 0);   // R8 all at once

    // R8: NMI beats IRQ, IRQ kept for the next wait
    iflag = 1'b0; enter_wait();
    nmi_n = 1'b0; irq_n = 1'b0; step(SYNC + 1);
    chk("R8 nmi first", 32'(obs()), 32'({2'b01, 4'b0100, 1'b0}));
    nmi_ack = 1'b1; step(1); nmi_ack = 1'b0; nmi_n = 1'b1; step(SYNC + 2);
    halt_op = 1'b1; step(1); halt_op = 1'b0;
    chk("R8 irq still pending", 32'({rdy, obs()}), 32'({1'b1, 2'b01, 4'b1000, 1'b0}));
    irq_n = 1'b1; step(SYNC + 2);

    // R9: masked IRQ already present, rdy never drops
    iflag = 1'b1; irq_n = 1'b0; step(SYNC + 1);
    halt_op = 1'b1; step(1); halt_op = 1'b0;
    chk("R9 immediate resume", 32'({rdy, clk_en, resume, take_vec}), 32'b1110);
    irq_n = 1'b1; step(SYNC + 2);

    // R11: NMI latched while running survives release, taken at next wait
    nmi_n = 1'b0; step(SYNC + 2); nmi_n = 1'b1; step(SYNC + 4);
    halt_op = 1'b1; step(1); halt_op = 1'b0;
    chk("R11 latched nmi", 32'({rdy, obs()}), 32'({1'b1, 2'b01, 4'b0100, 1'b0}));
    nmi_ack = 1'b1; step(1); nmi_ack = 1'b0;

    // R11: held-low NMI after ack does not relatch
    nmi_n = 1'b0; step(SYNC + 2);
    nmi_ack = 1'b1; step(1); nmi_ack = 1'b0;
    enter_wait(); step(4);
    chk("R11 held nmi no wake", 32'({rdy, obs()}), 0);
    exit_masked();
    nmi_n = 1'b1; step(SYNC + 2);

    // R7: reset request clears a latched NMI
    nmi_n = 1'b0; step(SYNC + 2);
    reset_req_n = 1'b0; step(SYNC + 1); reset_req_n = 1'b1; nmi_n = 1'b1; step(SYNC + 2);
    enter_wait(); step(4);
    chk("R7 nmi cleared", 32'({rdy, obs()}), 0);
    exit_masked();

    // constrained random
    for (int k = 0; k < 40; k++) begin
      logic r, a, n, i, f;
      r = ($urandom % 8) == 0;
      a = ($urandom % 4) == 0;
      n = $urandom % 2;
      i = $urandom % 2;
      f = $urandom % 2;
      if (!(r || a || n || i)) i = 1'b1;
      run_case(r, a, n, i, f);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule